// File: doc/BRIEF.md
# MII Receive Frame-Start Detector

This block sits on the receive side of a MAC that takes data from the PHY four bits at a time. It watches the receive nibble bus, the receive-data-valid input and the receive-error input. It skips the preamble and finds the start-of-frame delimiter. It then passes the frame body downstream as a stream of one nibble per clock, with a start marker, an end marker and a bad-frame flag. A buffer writer that follows it needs only these flags to store a frame and to drop it when the flag says so.

Only receive-data-valid sets the frame boundaries. Carrier sense plays no part. Nibbles are taken to be aligned to frame nibbles, so the delimiter is searched for at nibble positions only. Whatever arrives before the delimiter is tolerated and never causes the frame to be rejected. A PHY receive error anywhere while data-valid is held marks the frame bad. This is the same status a CRC failure gives, and the downstream logic discards the frame.

Every input is registered once and every output is registered. An output therefore reflects the inputs sampled two rising edges earlier.

Top module: `mii_rx_sfd_detect`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs are 0 on the following cycle. Any partial frame is dropped: once reset is released, no end marker appears for a frame that was open before the reset.
- R2: Nibbles that come before the delimiter, and the delimiter nibbles themselves, are never output. A payload nibble on `rxd_i` appears unchanged on `pl_data_o`, with `pl_valid_o` high, two rising edges after it is sampled. `pl_data_o` is 0 whenever `pl_valid_o` is low.
- R3: `pl_sof_o` is high only together with `pl_valid_o`, and only for the first payload nibble of a frame. This holds even when receive-error is set on that nibble.
- R4: Preamble content is not checked. Arbitrary nibbles before the delimiter (for example 3h, Ah) do not cause the frame to be rejected.
- R5: The delimiter is the nibble 5h followed directly by Dh. A run of 5h nibbles keeps the 5h-seen condition. Any other nibble after 5h (for example Ah) cancels it, and a later Dh with no 5h directly before it is not a delimiter.
- R6: When data-valid falls during a frame body, `pl_eof_o` is high for exactly one cycle, with `pl_valid_o` low in that cycle. This cycle comes directly after the output cycle of the last payload nibble.
- R7: `pl_bad_o` is sampled together with `pl_eof_o`. It is 1 if receive-error was high on any cycle in which data-valid was high since the frame armed, and 0 otherwise.
- R8: If data-valid falls before a delimiter is found, nothing is output: no valid, no start marker and no end marker.
- R9: After the delimiter, the nibbles 5h and Dh are ordinary payload data and do not restart detection.
- R10: If data-valid falls on the cycle right after the delimiter, the block gives an end marker with no payload and no start marker.
- R11: `pl_bad_o` is never high unless `pl_eof_o` is high in the same cycle.
- R12: A single low cycle of data-valid between two frames is enough. The end marker of the first frame and the arming for the second follow one another with no lost nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_dv_i | input | 1 | Receive data valid from the PHY |
| rx_er_i | input | 1 | Receive error from the PHY |
| rxd_i | input | 4 | Receive nibble from the PHY |
| pl_valid_o | output | 1 | Payload nibble strobe |
| pl_data_o | output | 4 | Payload nibble |
| pl_sof_o | output | 1 | First payload nibble of the frame |
| pl_eof_o | output | 1 | Frame closed, one-cycle pulse |
| pl_bad_o | output | 1 | Frame invalid, valid with the end marker |

## Verification
Two pairs of functions can meet in one cycle, and the stimulus brings both about on purpose. The first pair is the start marker and error capture: the first payload nibble arrives with receive-error set. The output must show the start marker on that cycle and then carry the error to the end marker two cycles later. The second pair is frame closing and re-arming: data-valid drops for one cycle right after a delimiter and then rises again at once with 5h Dh. The bench expects an empty frame's end marker that is clean, followed by a correct start of the new frame, with no nibble lost at the seam.

// File: rtl/mii_rxsfd_pkg.sv
package mii_rxsfd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_PREAMBLE = 2'd1,
    ST_SEEN5    = 2'd2,
    ST_PAYLOAD  = 2'd3
  } rxsfd_state_t;

endpackage

// File: rtl/rxsfd_in_reg.sv
module rxsfd_in_reg #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dv_i,
  input  logic             er_i,
  input  logic [NIB_W-1:0] d_i,
  output logic             dv_o,
  output logic             er_o,
  output logic [NIB_W-1:0] d_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_o <= 1'b0;
      er_o <= 1'b0;
      d_o  <= '0;
    end else begin
      dv_o <= dv_i;
      er_o <= er_i;
      d_o  <= d_i;
    end
  end

endmodule

// File: rtl/rxsfd_fsm.sv
module rxsfd_fsm
  import mii_rxsfd_pkg::*;
#(
  parameter int               NIB_W   = 4,
  parameter logic [NIB_W-1:0] PRE_NIB = 4'h5,
  parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dv,
  input  logic             er,
  input  logic [NIB_W-1:0] d,
  output logic             valid_o,
  output logic [NIB_W-1:0] data_o,
  output logic             sof_o,
  output logic             eof_o,
  output logic             bad_o
);

  rxsfd_state_t st;
  logic         first_q;
  logic         err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      first_q <= 1'b0;
      err_q   <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
      sof_o   <= 1'b0;
      eof_o   <= 1'b0;
      bad_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      data_o  <= '0;
      sof_o   <= 1'b0;
      eof_o   <= 1'b0;
      bad_o   <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          err_q <= dv & er;
          if (dv) st <= (d == PRE_NIB) ? ST_SEEN5 : ST_PREAMBLE;
        end
        ST_PREAMBLE: begin
          if (!dv) begin
            st    <= ST_IDLE;
            err_q <= 1'b0;
          end else begin
            err_q <= err_q | er;
            if (d == PRE_NIB) st <= ST_SEEN5;
          end
        end
        ST_SEEN5: begin
          if (!dv) begin
            st    <= ST_IDLE;
            err_q <= 1'b0;
          end else begin
            err_q <= err_q | er;
            if (d == SFD_NIB) begin
              st      <= ST_PAYLOAD;
              first_q <= 1'b1;
            end else if (d != PRE_NIB) begin
              st <= ST_PREAMBLE;
            end
          end
        end
        ST_PAYLOAD: begin
          if (dv) begin
            valid_o <= 1'b1;
            data_o  <= d;
            sof_o   <= first_q;
            first_q <= 1'b0;
            err_q   <= err_q | er;
          end else begin
            eof_o   <= 1'b1;
            bad_o   <= err_q;
            err_q   <= 1'b0;
            first_q <= 1'b0;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mii_rx_sfd_detect.sv
module mii_rx_sfd_detect #(
  parameter int               NIB_W   = 4,
  parameter logic [NIB_W-1:0] PRE_NIB = 4'h5,
  parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_dv_i,
  input  logic             rx_er_i,
  input  logic [NIB_W-1:0] rxd_i,
  output logic             pl_valid_o,
  output logic [NIB_W-1:0] pl_data_o,
  output logic             pl_sof_o,
  output logic             pl_eof_o,
  output logic             pl_bad_o
);

  logic             dv_s;
  logic             er_s;
  logic [NIB_W-1:0] d_s;

  rxsfd_in_reg #(.NIB_W(NIB_W)) u_in (
    .clk  (clk),
    .rst  (rst),
    .dv_i (rx_dv_i),
    .er_i (rx_er_i),
    .d_i  (rxd_i),
    .dv_o (dv_s),
    .er_o (er_s),
    .d_o  (d_s)
  );

  rxsfd_fsm #(
    .NIB_W   (NIB_W),
    .PRE_NIB (PRE_NIB),
    .SFD_NIB (SFD_NIB)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .dv      (dv_s),
    .er      (er_s),
    .d       (d_s),
    .valid_o (pl_valid_o),
    .data_o  (pl_data_o),
    .sof_o   (pl_sof_o),
    .eof_o   (pl_eof_o),
    .bad_o   (pl_bad_o)
  );

endmodule

// File: rtl/mii_rxsfd_chk.sv
module mii_rxsfd_chk #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_dv_i,
  input logic [NIB_W-1:0] rxd_i,
  input logic             pl_valid_o,
  input logic [NIB_W-1:0] pl_data_o,
  input logic             pl_sof_o,
  input logic             pl_eof_o,
  input logic             pl_bad_o
);

  // R3: start marker only on a payload nibble
  a_r3_sof_with_valid: assert property (@(posedge clk) disable iff (rst)
    pl_sof_o |-> pl_valid_o);

  // R11: bad flag only alongside the end marker
  a_r11_bad_only_eof: assert property (@(posedge clk) disable iff (rst)
    pl_bad_o |-> pl_eof_o);

  // R6: end marker cycle carries no nibble
  a_r6_eof_no_valid: assert property (@(posedge clk) disable iff (rst)
    pl_eof_o |-> !pl_valid_o);

  // R6: end marker lasts one cycle
  a_r6_eof_single: assert property (@(posedge clk) disable iff (rst)
    pl_eof_o |=> !pl_eof_o);

  // R2: payload nibble equals the input two edges earlier
  a_r2_data_path: assert property (@(posedge clk) disable iff (rst)
    pl_valid_o |-> (pl_data_o == $past(rxd_i, 2)));

  // R8: no payload unless data-valid was high at the matching input cycle
  a_r8_valid_needs_dv: assert property (@(posedge clk) disable iff (rst)
    pl_valid_o |-> $past(rx_dv_i, 2));

endmodule

bind mii_rx_sfd_detect mii_rxsfd_chk #(.NIB_W(NIB_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rx_dv_i    (rx_dv_i),
  .rxd_i      (rxd_i),
  .pl_valid_o (pl_valid_o),
  .pl_data_o  (pl_data_o),
  .pl_sof_o   (pl_sof_o),
  .pl_eof_o   (pl_eof_o),
  .pl_bad_o   (pl_bad_o)
);

// File: tb/test_mii_rx_sfd_detect.sv
module test_mii_rx_sfd_detect;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dv  = 1'b0;
  logic       er  = 1'b0;
  logic [3:0] rxd = 4'h0;
  logic       v, s, e, b;
  logic [3:0] dat;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  always #2 clk = ~clk;

  mii_rx_sfd_detect i_mii_rx_sfd_detect (
    .clk        (clk),
    .rst        (rst),
    .rx_dv_i    (dv),
    .rx_er_i    (er),
    .rxd_i      (rxd),
    .pl_valid_o (v),
    .pl_data_o  (dat),
    .pl_sof_o   (s),
    .pl_eof_o   (e),
    .pl_bad_o   (b)
  );

  // row: {tag, dv, er, nibble, expected {valid,sof,eof,bad,data}}
  // expected value is the response to the previous row's inputs
  localparam int NV = 34;
  localparam logic [17:0] VEC [NV] = '{
    {4'd2,  1'b0, 1'b0, 4'h0, 8'h00},
    {4'd2,  1'b1, 1'b0, 4'h5, 8'h00},
    {4'd2,  1'b1, 1'b0, 4'h5, 8'h00},
    {4'd2,  1'b1, 1'b0, 4'h5, 8'h00},
    {4'd2,  1'b1, 1'b0, 4'hD, 8'h00},
    {4'd2,  1'b1, 1'b0, 4'h1, 8'h00},
    {4'd3,  1'b1, 1'b0, 4'h2, 8'hC1},  // R3 first nibble
    {4'd2,  1'b1, 1'b0, 4'hD, 8'h82},
    {4'd9,  1'b0, 1'b0, 4'h0, 8'h8D},  // R9 Dh as data
    {4'd6,  1'b0, 1'b0, 4'h0, 8'h20},  // R6 end marker
    {4'd4,  1'b1, 1'b0, 4'h3, 8'h00},  // R4 junk preamble
    {4'd4,  1'b1, 1'b0, 4'hA, 8'h00},
    {4'd5,  1'b1, 1'b0, 4'h5, 8'h00},  // R5 5h then Ah
    {4'd5,  1'b1, 1'b0, 4'hA, 8'h00},
    {4'd5,  1'b1, 1'b0, 4'hD, 8'h00},
    {4'd5,  1'b1, 1'b0, 4'h5, 8'h00},
    {4'd5,  1'b1, 1'b0, 4'hD, 8'h00},
    {4'd5,  1'b1, 1'b1, 4'h7, 8'h00},
    {4'd4,  1'b1, 1'b0, 4'h8, 8'hC7},
    {4'd4,  1'b0, 1'b0, 4'h0, 8'h88},
    {4'd7,  1'b0, 1'b0, 4'h0, 8'h30},  // R7 bad frame
    {4'd8,  1'b1, 1'b0, 4'h5, 8'h00},  // R8 abort before delimiter
    {4'd8,  1'b1, 1'b0, 4'h5, 8'h00},
    {4'd8,  1'b0, 1'b0, 4'h0, 8'h00},
    {4'd8,  1'b0, 1'b0, 4'h0, 8'h00},
    {4'd10, 1'b1, 1'b0, 4'h5, 8'h00},  // R10 empty frame
    {4'd10, 1'b1, 1'b0, 4'hD, 8'h00},
    {4'd10, 1'b0, 1'b0, 4'h0, 8'h00},
    {4'd10, 1'b1, 1'b0, 4'h5, 8'h20},
    {4'd12, 1'b1, 1'b0, 4'hD, 8'h00},  // R12 re-arm after one gap
    {4'd3,  1'b1, 1'b1, 4'h5, 8'h00},
    {4'd3,  1'b0, 1'b0, 4'h0, 8'hC5},  // R3 sof with error
    {4'd7,  1'b0, 1'b0, 4'h0, 8'h30},  // R7 error carried to end
    {4'd2,  1'b0, 1'b0, 4'h0, 8'h00}
  };

  task automatic check(input int tag, input logic [7:0] exp);
    logic [7:0] act;
    act = {v, s, e, b, dat};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d: outputs {valid,sof,eof,bad,data} actual=%h expected=%h",
               tag, act, exp);
    end
  endtask

  task automatic step(input logic d_v, input logic d_e, input logic [3:0] n);
    @(negedge clk);
    dv  = d_v;
    er  = d_e;
    rxd = n;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1, 8'h00);  // R1 reset state
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][13], VEC[i][12], VEC[i][11:8]);
      check(int'(VEC[i][17:14]), VEC[i][7:0]);
    end

    // R1: reset in the middle of a frame body
    step(1'b1, 1'b1, 4'h5);
    step(1'b1, 1'b0, 4'hD);
    step(1'b1, 1'b0, 4'h1);
    step(1'b1, 1'b0, 4'h2);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(1, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    dv  = 1'b0;
    er  = 1'b0;
    step(1'b0, 1'b0, 4'h0);
    check(1, 8'h00);  // r1_ no stale end marker
    step(1'b0, 1'b0, 4'h0);
    check(1, 8'h00);

    // R2: recovery after reset, clean frame
    step(1'b1, 1'b0, 4'h5);
    step(1'b1, 1'b0, 4'hD);
    step(1'b1, 1'b0, 4'h9);
    step(1'b0, 1'b0, 4'h0);
    check(2, 8'hC9);
    step(1'b0, 1'b0, 4'h0);
    check(7, 8'h20);  // R7 clean after reset

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule